// File: doc/BRIEF.md
# Linear-Address Alignment Guard

This block sits in front of a memory access path. Each cycle it may accept one load request. The request carries a segment base, an effective offset, an access size, the current privilege level, a control word and a flags word. The block adds base and offset to form the linear address. It then decides whether the access raises an alignment fault, raises a page fault, or proceeds.

The alignment test is made on the linear address, not on the offset alone. A suitable base can therefore make an aligned offset fault. The test runs before any translation is tried. A misaligned access with checking active raises no translation request, and the page-present answer for it is ignored.

An access that passes the test, or that has checking switched off, raises a translation request in the same cycle. The simple lookup answers with a page-present bit in that same cycle. One cycle after acceptance the block presents a registered result. The result holds the linear address, the instruction pointer of the faulting instruction and a two-bit fault code.

Top module: `lin_align_guard`

## Requirements
- R1: The linear address is seg_base + eff_off modulo 2^32. It appears on xlat_addr in the request cycle and on res_lin in the result cycle.
- R2: Size codes 0 to 4 select 1, 2, 4, 8 and 16 bytes. Codes 5 to 7 are treated as 16 bytes. An access is misaligned when the linear address ANDed with (bytes - 1) is nonzero.
- R3: Checking is active only when priv_lvl equals 3, bit 18 of ctrl_word is 1 and bit 18 of flag_word is 1. All other bits of both words are ignored. With checking inactive, no alignment fault is raised.
- R4: A misaligned access with checking active gives res_code 01. xlat_req stays low in its request cycle, and page_present has no effect on its result.
- R5: Any other accepted request drives xlat_req high in its request cycle. It then gives res_code 10 when page_present is 0 in that cycle, and res_code 00 when page_present is 1.
- R6: res_vld is high for exactly the one cycle after each accepted request. res_code is 00 whenever res_vld is low.
- R7: res_ip equals the instr_ip of the request itself, because both fault kinds are faults and not traps.
- R8: A synchronous active-high reset clears res_vld, res_code, res_lin and res_ip. It also holds xlat_req low, and it discards a request accepted in the same cycle.
- R9: Requests in consecutive cycles each produce their own result, one cycle after their own acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A load request is presented this cycle |
| seg_base | input | 32 | Segment base address |
| eff_off | input | 32 | Effective offset within the segment |
| size_code | input | 3 | log2 of the access size in bytes |
| priv_lvl | input | 2 | Current privilege level |
| ctrl_word | input | 32 | Control register image; bit 18 enables checking |
| flag_word | input | 32 | Flags register image; bit 18 enables checking |
| instr_ip | input | 32 | Address of the load instruction |
| page_present | input | 1 | Lookup answer, sampled with xlat_req |
| xlat_req | output | 1 | Translation request for this cycle's access |
| xlat_addr | output | 32 | Linear address sent to the lookup |
| res_vld | output | 1 | Result strobe, one cycle after acceptance |
| res_code | output | 2 | 00 none, 01 alignment fault, 10 page fault |
| res_lin | output | 32 | Linear address of the reported access |
| res_ip | output | 32 | Instruction pointer of the reported access |

## Verification
The hardest case to reach is a misaligned access to an unmapped page that must still report only the alignment fault. The stimulus reaches it with an odd base and an offset on a 4-byte boundary, with page_present held low during the request cycle. A correct design shows code 01 and no translation request. Other vectors use the same low page_present with the enables cleared or with an aligned sum, and these must give code 10. Wrap-around of the sum past 2^32 is reached with an all-ones base.

// File: rtl/lac_pkg.sv
package lac_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_ALIGN = 2'b01,
    FLT_PAGE  = 2'b10
  } flt_e;
endpackage

// File: rtl/lac_addr_form.sv
module lac_addr_form #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] lin
);
  // modulo 2^AW: carry out is dropped
  assign lin = base + offset;
endmodule

// File: rtl/lac_align_test.sv
module lac_align_test #(
  parameter int AW       = 32,
  parameter int SZW      = 3,
  parameter int MAX_LOG2 = 4
) (
  input  logic [AW-1:0]  lin,
  input  logic [SZW-1:0] size_code,
  output logic           misaligned
);
  logic [MAX_LOG2-1:0] low_mask;

  // bit b of the mask is set when the size exceeds 2^b bytes; codes above
  // MAX_LOG2 set every bit and so saturate at the widest size
  for (genvar b = 0; b < MAX_LOG2; b++) begin : g_mask
    assign low_mask[b] = (size_code > SZW'(b));
  end

  assign misaligned = |(lin[MAX_LOG2-1:0] & low_mask);
endmodule

// File: rtl/lac_gate.sv
module lac_gate #(
  parameter int CW      = 32,
  parameter int PLW     = 2,
  parameter int USER_PL = 3,
  parameter int AM_BIT  = 18,
  parameter int AC_BIT  = 18
) (
  input  logic [PLW-1:0] priv_lvl,
  input  logic [CW-1:0]  ctrl_word,
  input  logic [CW-1:0]  flag_word,
  output logic           chk_on
);
  assign chk_on = (priv_lvl == PLW'(USER_PL)) & ctrl_word[AM_BIT] & flag_word[AC_BIT];
endmodule

// File: rtl/lin_align_guard.sv
module lin_align_guard #(
  parameter int AW       = 32,
  parameter int SZW      = 3,
  parameter int MAX_LOG2 = 4,
  parameter int PLW      = 2,
  parameter int CW       = 32,
  parameter int USER_PL  = 3,
  parameter int AM_BIT   = 18,
  parameter int AC_BIT   = 18
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [AW-1:0]  seg_base,
  input  logic [AW-1:0]  eff_off,
  input  logic [SZW-1:0] size_code,
  input  logic [PLW-1:0] priv_lvl,
  input  logic [CW-1:0]  ctrl_word,
  input  logic [CW-1:0]  flag_word,
  input  logic [AW-1:0]  instr_ip,
  input  logic           page_present,
  output logic           xlat_req,
  output logic [AW-1:0]  xlat_addr,
  output logic           res_vld,
  output logic [1:0]     res_code,
  output logic [AW-1:0]  res_lin,
  output logic [AW-1:0]  res_ip
);
  import lac_pkg::*;

  logic [AW-1:0] lin;
  logic          mis;
  logic          chk_on;
  logic          ac_hit;
  flt_e          next_code;

  lac_addr_form #(.AW(AW)) u_addr (
    .base   (seg_base),
    .offset (eff_off),
    .lin    (lin)
  );

  lac_align_test #(.AW(AW), .SZW(SZW), .MAX_LOG2(MAX_LOG2)) u_align (
    .lin        (lin),
    .size_code  (size_code),
    .misaligned (mis)
  );

  lac_gate #(.CW(CW), .PLW(PLW), .USER_PL(USER_PL),
             .AM_BIT(AM_BIT), .AC_BIT(AC_BIT)) u_gate (
    .priv_lvl  (priv_lvl),
    .ctrl_word (ctrl_word),
    .flag_word (flag_word),
    .chk_on    (chk_on)
  );

  // alignment is resolved first; a failing access never reaches translation
  assign ac_hit    = chk_on & mis;
  assign xlat_req  = ~rst & req_valid & ~ac_hit;
  assign xlat_addr = lin;

  always_comb begin
    if (ac_hit)             next_code = FLT_ALIGN;
    else if (!page_present) next_code = FLT_PAGE;
    else                    next_code = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld  <= 1'b0;
      res_code <= FLT_NONE;
      res_lin  <= '0;
      res_ip   <= '0;
    end else begin
      res_vld  <= req_valid;
      res_code <= req_valid ? next_code : FLT_NONE;
      if (req_valid) begin
        res_lin <= lin;
        res_ip  <= instr_ip;
      end
    end
  end
endmodule

// File: rtl/lac_chk.sv
module lac_chk #(
  parameter int AW       = 32,
  parameter int SZW      = 3,
  parameter int MAX_LOG2 = 4,
  parameter int PLW      = 2,
  parameter int CW       = 32,
  parameter int USER_PL  = 3,
  parameter int AM_BIT   = 18,
  parameter int AC_BIT   = 18
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic [AW-1:0]  seg_base,
  input logic [AW-1:0]  eff_off,
  input logic [SZW-1:0] size_code,
  input logic [PLW-1:0] priv_lvl,
  input logic [CW-1:0]  ctrl_word,
  input logic [CW-1:0]  flag_word,
  input logic [AW-1:0]  instr_ip,
  input logic           page_present,
  input logic           xlat_req,
  input logic [AW-1:0]  xlat_addr,
  input logic           res_vld,
  input logic [1:0]     res_code,
  input logic [AW-1:0]  res_lin,
  input logic [AW-1:0]  res_ip
);
  // R6: strobe follows acceptance by one cycle
  a_r6_vld_after_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_vld);
  a_r6_no_vld_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_vld);
  a_r6_code_quiet: assert property (@(posedge clk) disable iff (rst)
    !res_vld |-> res_code == 2'b00);
  // R4: an alignment fault never had a translation request
  a_r4_align_no_xlat: assert property (@(posedge clk) disable iff (rst)
    req_valid ##1 (res_code == 2'b01) |-> !$past(xlat_req));
  // R5: page fault only after a request that saw no page
  a_r5_page_after_miss: assert property (@(posedge clk) disable iff (rst)
    req_valid ##1 (res_code == 2'b10) |-> $past(xlat_req) && !$past(page_present));
  // R3: alignment fault only with all three enables
  a_r3_align_enabled: assert property (@(posedge clk) disable iff (rst)
    req_valid ##1 (res_code == 2'b01) |->
      $past(priv_lvl) == PLW'(USER_PL) && $past(ctrl_word[AM_BIT]) && $past(flag_word[AC_BIT]));
  // R1: the request address reappears in the result
  a_r1_lin_kept: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_lin == $past(xlat_addr));
  // R7: instruction pointer of the request itself
  a_r7_ip_kept: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_ip == $past(instr_ip));
  // R8: reset clears the strobe
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> !res_vld && res_code == 2'b00);
  // R5: no request without an accepted access
  a_r5_xlat_needs_req: assert property (@(posedge clk)
    xlat_req |-> req_valid && !rst);
endmodule

bind lin_align_guard lac_chk #(
  .AW(AW), .SZW(SZW), .MAX_LOG2(MAX_LOG2), .PLW(PLW), .CW(CW),
  .USER_PL(USER_PL), .AM_BIT(AM_BIT), .AC_BIT(AC_BIT)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .seg_base(seg_base),
  .eff_off(eff_off), .size_code(size_code), .priv_lvl(priv_lvl),
  .ctrl_word(ctrl_word), .flag_word(flag_word), .instr_ip(instr_ip),
  .page_present(page_present), .xlat_req(xlat_req), .xlat_addr(xlat_addr),
  .res_vld(res_vld), .res_code(res_code), .res_lin(res_lin), .res_ip(res_ip)
);

// File: tb/sim_lin_align_guard.sv
module sim_lin_align_guard;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] seg_base, eff_off, ctrl_word, flag_word, instr_ip;
  logic [2:0]  size_code;
  logic [1:0]  priv_lvl;
  logic        page_present;
  logic        xlat_req;
  logic [31:0] xlat_addr, res_lin, res_ip;
  logic        res_vld;
  logic [1:0]  res_code;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  lin_align_guard u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .seg_base(seg_base),
    .eff_off(eff_off), .size_code(size_code), .priv_lvl(priv_lvl),
    .ctrl_word(ctrl_word), .flag_word(flag_word), .instr_ip(instr_ip),
    .page_present(page_present), .xlat_req(xlat_req), .xlat_addr(xlat_addr),
    .res_vld(res_vld), .res_code(res_code), .res_lin(res_lin), .res_ip(res_ip)
  );

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] off;
    logic [2:0]  sz;
    logic [1:0]  pl;
    logic        am;
    logic        ac;
    logic        pres;
    logic [1:0]  code;
    logic        xreq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{32'h0, 32'h7000, 3'd2, 2'd3, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1},
    '{32'h0, 32'h7001, 3'd2, 2'd3, 1'b1, 1'b1, 1'b1, 2'b01, 1'b0},
    '{32'h1, 32'h7000, 3'd2, 2'd3, 1'b1, 1'b1, 1'b1, 2'b01, 1'b0},
    '{32'h1, 32'h7003, 3'd2, 2'd3, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1},
    '{32'h1, 32'h8003, 3'd2, 2'd3, 1'b1, 1'b1, 1'b0, 2'b10, 1'b1},
    '{32'h1, 32'h8000, 3'd2, 2'd3, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0},
    '{32'h1, 32'h7000, 3'd2, 2'd0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1},
    '{32'h1, 32'h7000, 3'd2, 2'd3, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1},
    '{32'h1, 32'h7000, 3'd2, 2'd3, 1'b1, 1'b0, 1'b0, 2'b10, 1'b1},
    '{32'hFFFFFFFF, 32'h1, 3'd4, 2'd3, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1},
    '{32'h8, 32'h0, 3'd4, 2'd3, 1'b1, 1'b1, 1'b1, 2'b01, 1'b0},
    '{32'h8, 32'h0, 3'd3, 2'd3, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1},
    '{32'h1, 32'h0, 3'd0, 2'd3, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1},
    '{32'h2, 32'h0, 3'd7, 2'd3, 1'b1, 1'b1, 1'b1, 2'b01, 1'b0},
    '{32'h3, 32'h0, 3'd1, 2'd2, 1'b1, 1'b1, 1'b0, 2'b10, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; seg_base = '0; eff_off = '0; size_code = '0;
    priv_lvl = '0; ctrl_word = '0; flag_word = '0; instr_ip = '0;
    page_present = 1'b1;
  endtask

  // every other bit of both words is set, so only bit 18 may matter (R3)
  task automatic drive(input vec_t v, input logic [31:0] ip);
    req_valid = 1'b1; seg_base = v.base; eff_off = v.off; size_code = v.sz;
    priv_lvl = v.pl;
    ctrl_word = 32'hFFFB_FFFF | (32'(v.am) << 18);
    flag_word = 32'hFFFB_FFFF | (32'(v.ac) << 18);
    instr_ip = ip; page_present = v.pres;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset res_vld", 32'(res_vld), 32'd0);
    chk("R8 reset res_code", 32'(res_code), 32'd0);
    chk("R8 reset res_lin", res_lin, 32'd0);
    chk("R8 reset xlat_req", 32'(xlat_req), 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] ip, lin;
      ip  = 32'h1000 + 32'(i) * 4;
      lin = VECS[i].base + VECS[i].off;
      drive(VECS[i], ip);
      #1;
      chk($sformatf("R1 xlat_addr v%0d", i), xlat_addr, lin);
      chk($sformatf("R4/R5 xlat_req v%0d", i), 32'(xlat_req), 32'(VECS[i].xreq));
      @(negedge clk);
      idle();
      chk($sformatf("R6 res_vld v%0d", i), 32'(res_vld), 32'd1);
      chk($sformatf("R2/R3/R4/R5 res_code v%0d", i), 32'(res_code), 32'(VECS[i].code));
      chk($sformatf("R1 res_lin v%0d", i), res_lin, lin);
      chk($sformatf("R7 res_ip v%0d", i), res_ip, ip);
      @(negedge clk);
      chk($sformatf("R6 strobe drop v%0d", i), 32'(res_vld), 32'd0);
      chk($sformatf("R6 code quiet v%0d", i), 32'(res_code), 32'd0);
    end

    // R9: back-to-back, misaligned then page miss
    drive(VECS[2], 32'hA0);
    @(negedge clk);
    drive(VECS[4], 32'hA4);
    chk("R9 first code", 32'(res_code), 32'b01);
    chk("R9 first ip", res_ip, 32'hA0);
    @(negedge clk);
    idle();
    chk("R9 second vld", 32'(res_vld), 32'd1);
    chk("R9 second code", 32'(res_code), 32'b10);
    chk("R9 second ip", res_ip, 32'hA4);
    @(negedge clk);

    // R8: reset discards a request in the same cycle
    drive(VECS[4], 32'hB0);
    rst = 1'b1;
    #1;
    chk("R8 xlat_req under reset", 32'(xlat_req), 32'd0);
    @(negedge clk);
    idle();
    rst = 1'b0;
    chk("R8 discarded vld", 32'(res_vld), 32'd0);
    chk("R8 discarded code", 32'(res_code), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule